// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block sits between a processor port and a memory bus and answers the processor from a two-way set-associative store. Each way holds `SETS` lines of 32 bytes. A processor address is split into three fields: bits [4:3] select the 64-bit word in a line, the next log2(`SETS`) bits select the set, and the remaining upper bits form the tag. A miss refills the whole line with four 64-bit read beats on the memory bus. Before that refill, the line being replaced is written back if it is modified.

Two level inputs choose the mode of operation. `cache_off` routes every access straight to memory as a single beat. `wb_mode` selects between write-back and write-through. In write-back mode, write hits stay in the cache and write misses allocate the line. In write-through mode, every write goes to memory and write misses do not allocate.

Other bus masters report their writes on the snoop port, one line address at a time. A snooped line that is present is invalidated, and it is written back first if it is modified. A flush request scans every entry, writes back each modified line and then invalidates the whole store. `busy` stays high during refills, write-backs and flushes.

Top module: `twoway_cache`

## Requirements
- R1: After reset, `busy`, `mem_req` and `cpu_ready` are low and every line is invalid, so the first read of any address is a miss.
- R2: A cached read miss fetches the line as four single-beat memory reads. The beat addresses are line base + 0, 8, 16 and 24, in that order. The requested word is then returned.
- R3: A read hit while the block is idle raises `cpu_ready` in the cycle of the request and returns the stored word with no memory cycle.
- R4: Two lines with the same set index and different tags are held at the same time, one per way, and at most one way matches a lookup.
- R5: On a miss, an invalid way is filled first. Otherwise the least recently used way of the set is replaced. Every hit makes the other way of its set the least recently used one.
- R6: A modified victim is written back as four write beats (line base + 0, 8, 16, 24) before the four refill read beats start.
- R7: With `cache_off` = 1, every read and every write is one memory beat, and `cpu_ready` rises only with `mem_ack`. The stored lines are left untouched and hit again once `cache_off` returns to 0.
- R8: With `wb_mode` = 0, a write becomes one memory write beat and completes only with `mem_ack`. A write hit also updates the cached copy. A write miss does not allocate a line.
- R9: With `wb_mode` = 1, a write hit changes only the cache and marks the line modified, with no memory cycle. A write miss refills the line, merges the write data and marks the line modified.
- R10: Bit i of `cpu_be` enables byte i (data bits 8i+7 down to 8i) of a write. Disabled bytes keep their value.
- R11: A snoop presented while `busy` is low invalidates a matching line. A matching modified line is first written back in four beats. A snoop that matches no line changes nothing.
- R12: After `flush_req`, `busy` goes high. Every modified line is written back, and then all lines of both ways are invalid.
- R13: Once `mem_req` is raised, it stays high with a stable `mem_addr` until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_off | input | 1 | 1: bypass the cache for all accesses |
| wb_mode | input | 1 | 1: write-back, 0: write-through |
| cpu_valid | input | 1 | Processor request valid, held until `cpu_ready` |
| cpu_ready | output | 1 | Processor request completes this cycle |
| cpu_we | input | 1 | 1: write, 0: read |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_be | input | 8 | Write byte enables |
| cpu_wdata | input | 64 | Write data |
| cpu_rdata | output | 64 | Read data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | ADDR_W | Memory beat address, 8-byte aligned |
| mem_be | output | 8 | Memory write byte enables |
| mem_wdata | output | 64 | Memory write data |
| mem_ack | input | 1 | Memory accepts or returns the current beat |
| mem_rdata | input | 64 | Memory read data, valid with `mem_ack` |
| snoop_valid | input | 1 | Another master wrote the line on `snoop_line` |
| snoop_line | input | ADDR_W-5 | Snooped line address (byte address bits above 4) |
| flush_req | input | 1 | Start a flush |
| busy | output | 1 | Refill, write-back or flush in progress |

## Verification
The hardest case to reach is the replacement of a modified line by its own set, because the victim depends on the history of hits in that set. The stimulus builds that history on purpose. It fills both ways of a small four-set configuration, then re-reads them so that a known way becomes the least recently used one. It writes into that way in write-back mode, touches the other way, and then misses on a third tag. The recorded bus beats must show four writes of the old line followed by four reads of the new one. The snoop and flush cases are reached the same way: a line is first made dirty by a write hit, and only then is the snoop or flush raised.

// File: rtl/twoway_cache.sv
module twoway_cache #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_off,
  input  logic              wb_mode,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_be,
  input  logic [63:0]       cpu_wdata,
  output logic [63:0]       cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_be,
  output logic [63:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [63:0]       mem_rdata,
  input  logic              snoop_valid,
  input  logic [ADDR_W-6:0] snoop_line,
  input  logic              flush_req,
  output logic              busy
);
  localparam int IW   = $clog2(SETS);
  localparam int TW   = ADDR_W - IW - 5;
  localparam int EW   = IW + 1;
  localparam int NENT = 2 * SETS;
  localparam logic [1:0] C_MISS = 2'd0, C_SNOOP = 2'd1, C_FLUSH = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_ONE, S_WB, S_FILL, S_SCAN} st_t;

  st_t             state;
  logic [1:0]      beat, cause;
  logic [IW-1:0]   sel_set;
  logic            sel_way;
  logic [TW-1:0]   sel_tag;
  logic [EW:0]     scan;
  logic [TW-1:0]   tag_q [NENT];
  logic [63:0]     dat_q [NENT*4];
  logic [NENT-1:0] val_q, dty_q;
  logic [SETS-1:0] lru_q;

  function automatic logic [63:0] merge(input logic [63:0] old_w, input logic [63:0] new_w,
                                        input logic [7:0] be);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = be[i] ? new_w[8*i +: 8] : old_w[8*i +: 8];
    return r;
  endfunction

  wire [IW-1:0] a_set = cpu_addr[IW+4:5];
  wire [TW-1:0] a_tag = cpu_addr[ADDR_W-1:IW+5];
  wire [1:0]    a_wd  = cpu_addr[4:3];
  wire [IW-1:0] s_set = snoop_line[IW-1:0];
  wire [TW-1:0] s_tag = snoop_line[ADDR_W-6:IW];

  wire hit0 = val_q[{1'b0, a_set}] && (tag_q[{1'b0, a_set}] == a_tag);
  wire hit1 = val_q[{1'b1, a_set}] && (tag_q[{1'b1, a_set}] == a_tag);
  wire hit  = (hit0 || hit1) && !cache_off;
  wire hway = hit1;

  wire s_hit0 = val_q[{1'b0, s_set}] && (tag_q[{1'b0, s_set}] == s_tag);
  wire s_hit1 = val_q[{1'b1, s_set}] && (tag_q[{1'b1, s_set}] == s_tag);
  wire s_way  = s_hit1;

  wire vic = !val_q[{1'b0, a_set}] ? 1'b0 : !val_q[{1'b1, a_set}] ? 1'b1 : lru_q[a_set];

  wire go_snoop = !flush_req && snoop_valid;
  wire go_cpu   = !flush_req && !snoop_valid && cpu_valid;
  wire fast     = (state == S_IDLE) && go_cpu && hit && (!cpu_we || wb_mode);

  wire [EW-1:0] scan_e = scan[EW-1:0];
  wire [EW-1:0] sel_e  = {sel_way, sel_set};

  assign cpu_ready = fast || ((state == S_ONE) && mem_ack);
  assign cpu_rdata = (state == S_ONE) ? mem_rdata : dat_q[{hway, a_set, a_wd}];
  assign busy      = (state != S_IDLE);
  assign mem_req   = (state == S_ONE) || (state == S_WB) || (state == S_FILL);
  assign mem_we    = ((state == S_ONE) && cpu_we) || (state == S_WB);
  assign mem_be    = ((state == S_ONE) && cpu_we) ? cpu_be : 8'hFF;
  assign mem_wdata = (state == S_WB) ? dat_q[{sel_e, beat}] : cpu_wdata;

  always_comb begin
    case (state)
      S_ONE:   mem_addr = cpu_addr & ~ADDR_W'(7);
      S_WB:    mem_addr = {tag_q[sel_e], sel_set, beat, 3'b000};
      S_FILL:  mem_addr = {sel_tag, sel_set, beat, 3'b000};
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; beat <= '0; cause <= C_MISS;
      sel_set <= '0; sel_way <= 1'b0; sel_tag <= '0; scan <= '0;
      val_q <= '0; dty_q <= '0; lru_q <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (flush_req) begin
            state <= S_SCAN; scan <= '0;
          end else if (go_snoop && (s_hit0 || s_hit1)) begin
            sel_set <= s_set; sel_way <= s_way;
            if (dty_q[{s_way, s_set}]) begin
              cause <= C_SNOOP; beat <= '0; state <= S_WB;
            end else val_q[{s_way, s_set}] <= 1'b0;
          end else if (go_cpu) begin
            if (fast) begin
              lru_q[a_set] <= ~hway;
              if (cpu_we) dty_q[{hway, a_set}] <= 1'b1;
            end else if (cache_off || (cpu_we && !wb_mode)) begin
              state <= S_ONE;
            end else begin
              sel_set <= a_set; sel_way <= vic; sel_tag <= a_tag; beat <= '0;
              if (val_q[{vic, a_set}] && dty_q[{vic, a_set}]) begin
                cause <= C_MISS; state <= S_WB;
              end else state <= S_FILL;
            end
          end
        end
        S_ONE: if (mem_ack) begin
          state <= S_IDLE;
          if (hit) lru_q[a_set] <= ~hway;
        end
        S_WB: if (mem_ack) begin
          beat <= beat + 2'd1;
          if (beat == 2'd3) begin
            dty_q[sel_e] <= 1'b0;
            case (cause)
              C_MISS:  state <= S_FILL;
              C_SNOOP: begin val_q[sel_e] <= 1'b0; state <= S_IDLE; end
              default: begin scan <= scan + (EW+1)'(1); state <= S_SCAN; end
            endcase
          end
        end
        S_FILL: if (mem_ack) begin
          beat <= beat + 2'd1;
          if (beat == 2'd3) begin
            val_q[sel_e] <= 1'b1; dty_q[sel_e] <= 1'b0; state <= S_IDLE;
          end
        end
        S_SCAN: begin
          if (scan == (EW+1)'(NENT)) begin
            val_q <= '0; dty_q <= '0; state <= S_IDLE;
          end else if (val_q[scan_e] && dty_q[scan_e]) begin
            {sel_way, sel_set} <= scan_e; cause <= C_FLUSH; beat <= '0; state <= S_WB;
          end else scan <= scan + (EW+1)'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if ((state == S_FILL) && mem_ack) begin
      dat_q[{sel_e, beat}] <= mem_rdata;
      if (beat == 2'd3) tag_q[sel_e] <= sel_tag;
    end
    if (cpu_ready && hit && cpu_we)
      dat_q[{hway, a_set, a_wd}] <= merge(dat_q[{hway, a_set, a_wd}], cpu_wdata, cpu_be);
  end

  a_r4_one_way_matches: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit0, hit1}));
  a_r2_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FILL && mem_ack && beat == 2'd3) |=> val_q[$past(sel_e)]);
  a_r9_wb_hit_marks_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && cpu_ready && cpu_we) |=> dty_q[$past({hway, a_set})]);
  a_r8_wt_write_waits_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we && !wb_mode && !cache_off) |-> mem_ack);
  a_r7_bypass_waits_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cache_off) |-> mem_ack);
  a_r12_flush_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !busy) |=> busy);
  a_r13_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: tb/twoway_cache_tb.sv
`timescale 1ns/1ps
module twoway_cache_tb;
  localparam int AW = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cache_off = 1'b0, wb_mode = 1'b1;
  logic cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0] cpu_be = '0;
  logic [63:0] cpu_wdata = '0;
  logic cpu_ready, mem_req, mem_we, busy;
  logic [63:0] cpu_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_be;
  logic mem_ack = 1'b0;
  logic snoop_valid = 1'b0, flush_req = 1'b0;
  logic [AW-6:0] snoop_line = '0;

  int n_cmp = 0, n_bad = 0;
  int rd_cnt = 0, wr_cnt = 0, hs_err = 0;
  logic [63:0] mem [512];
  logic [63:0] shadow [512];
  logic seq_we [256];
  logic [AW-1:0] seq_a [256];
  logic [7:0] seq_n = '0;
  logic pend = 1'b0;
  logic [AW-1:0] pend_a = '0;

  always #4 clk = ~clk;

  twoway_cache #(.ADDR_W(AW), .SETS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .cache_off(cache_off), .wb_mode(wb_mode),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_be(cpu_be), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .snoop_valid(snoop_valid), .snoop_line(snoop_line), .flush_req(flush_req), .busy(busy));

  function automatic logic [63:0] init_val(input int i);
    return (64'(i) * 64'h9E37_79B9_7F4A_7C15) ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  function automatic logic [63:0] mrg(input logic [63:0] o, input logic [63:0] n, input logic [7:0] be);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = be[i] ? n[8*i +: 8] : o[8*i +: 8];
    return r;
  endfunction

  function automatic logic [AW-1:0] A(input int t, input int s, input int w);
    return AW'((t << 7) | (s << 5) | (w << 3));
  endfunction

  assign mem_rdata = mem[mem_addr[AW-1:3]];

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      for (int i = 0; i < 512; i++) mem[i] <= init_val(i);
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (pend && (!mem_req || mem_addr != pend_a)) hs_err <= hs_err + 1;
      pend <= mem_req && !mem_ack;
      pend_a <= mem_addr;
      if (mem_req && mem_ack) begin
        if (mem_we) begin
          mem[mem_addr[AW-1:3]] <= mrg(mem[mem_addr[AW-1:3]], mem_wdata, mem_be);
          wr_cnt <= wr_cnt + 1;
        end else rd_cnt <= rd_cnt + 1;
        seq_we[seq_n] <= mem_we;
        seq_a[seq_n] <= mem_addr;
        seq_n <= seq_n + 8'd1;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [AW-1:0] a, input logic [7:0] be,
                      input logic [63:0] d, input string tag, input int erd, input int ewr);
    int r0, w0;
    logic [63:0] q;
    r0 = rd_cnt; w0 = wr_cnt;
    cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = d; cpu_valid = 1'b1;
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    q = cpu_rdata;
    @(posedge clk);
    #1 cpu_valid = 1'b0;
    if (we) shadow[a[AW-1:3]] = mrg(shadow[a[AW-1:3]], d, be);
    else chk({tag, " data"}, q, shadow[a[AW-1:3]]);
    chk({tag, " read beats"}, 64'(rd_cnt - r0), 64'(erd));
    chk({tag, " write beats"}, 64'(wr_cnt - w0), 64'(ewr));
  endtask

  task automatic snoop(input logic [AW-1:0] a, input string tag, input int ewr);
    int w0;
    w0 = wr_cnt;
    snoop_line = a[AW-1:5]; snoop_valid = 1'b1;
    @(posedge clk);
    #1 snoop_valid = 1'b0;
    @(negedge clk);
    while (busy) @(negedge clk);
    chk({tag, " snoop write beats"}, 64'(wr_cnt - w0), 64'(ewr));
    @(posedge clk); #1;
  endtask

  function automatic int mem_diff();
    int n = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== shadow[i]) n++;
    return n;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int w0;
    logic [7:0] sb;
    for (int i = 0; i < 512; i++) shadow[i] = init_val(i);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", 64'(busy), 0);
    chk("R1 mem_req after reset", 64'(mem_req), 0);
    chk("R1 cpu_ready after reset", 64'(cpu_ready), 0);
    @(posedge clk); #1;

    // R1 R2 R4: fill both ways of every set, then hit all 32 words
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 2; t++) xfer(1'b0, A(t, s, s), 8'h00, '0, "R2 miss refill", 4, 0);
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 2; t++)
        for (int w = 0; w < 4; w++) xfer(1'b0, A(t, s, w), 8'h00, '0, "R3 R4 hit", 0, 0);

    // R5: LRU replacement in set 0
    xfer(1'b0, A(0, 0, 0), 8'h00, '0, "R5 touch way0", 0, 0);
    xfer(1'b0, A(2, 0, 1), 8'h00, '0, "R5 third tag", 4, 0);
    xfer(1'b0, A(0, 0, 2), 8'h00, '0, "R5 recent kept", 0, 0);
    xfer(1'b0, A(1, 0, 3), 8'h00, '0, "R5 lru evicted", 4, 0);

    // R9 R10: write-back hits and per-byte enables in set 1
    xfer(1'b1, A(0, 1, 2), 8'h0F, 64'hDEAD_BEEF_CAFE_F00D, "R9 wb write hit", 0, 0);
    chk("R9 memory untouched", mem[A(0, 1, 2) >> 3], init_val(A(0, 1, 2) >> 3));
    xfer(1'b0, A(0, 1, 2), 8'h00, '0, "R10 partial merge", 0, 0);
    for (int i = 0; i < 8; i++) begin
      sb = 8'(i * 17 + 3);
      xfer(1'b1, A(0, 1, 2), 8'(1 << i), {8{sb}}, "R10 byte write", 0, 0);
      xfer(1'b0, A(0, 1, 2), 8'h00, '0, "R10 byte readback", 0, 0);
    end

    // R6: dirty victim written back before refill
    xfer(1'b0, A(1, 1, 0), 8'h00, '0, "R6 touch clean way", 0, 0);
    w0 = seq_n;
    xfer(1'b0, A(2, 1, 0), 8'h00, '0, "R6 dirty eviction", 4, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R6 writeback first", 64'(seq_we[8'(w0 + k)]), 1);
      chk("R6 writeback address", 64'(seq_a[8'(w0 + k)]), 64'(A(0, 1, k)));
      chk("R6 refill after", 64'(seq_we[8'(w0 + 4 + k)]), 0);
      chk("R2 refill address order", 64'(seq_a[8'(w0 + 4 + k)]), 64'(A(2, 1, k)));
    end
    chk("R6 memory holds written-back line", 64'(mem_diff()), 0);

    // R11: snoops
    xfer(1'b1, A(0, 2, 1), 8'hFF, 64'h1111_2222_3333_4444, "R11 make dirty", 0, 0);
    snoop(A(0, 2, 3), "R11 dirty", 4);
    chk("R11 snoop writeback content", 64'(mem_diff()), 0);
    xfer(1'b0, A(0, 2, 1), 8'h00, '0, "R11 dirty line invalidated", 4, 0);
    snoop(A(1, 3, 0), "R11 clean", 0);
    xfer(1'b0, A(1, 3, 0), 8'h00, '0, "R11 clean line invalidated", 4, 0);
    snoop(A(9, 3, 0), "R11 no match", 0);
    xfer(1'b0, A(0, 3, 0), 8'h00, '0, "R11 unmatched keeps line", 0, 0);

    // R8: write-through
    wb_mode = 1'b0;
    xfer(1'b1, A(0, 2, 1), 8'hF0, 64'h5555_6666_7777_8888, "R8 wt write hit", 0, 1);
    chk("R8 memory updated", 64'(mem_diff()), 0);
    xfer(1'b0, A(0, 2, 1), 8'h00, '0, "R8 cached copy updated", 0, 0);
    xfer(1'b1, A(5, 0, 0), 8'hFF, 64'h0F0F_0F0F_0F0F_0F0F, "R8 wt write miss", 0, 1);
    xfer(1'b0, A(5, 0, 0), 8'h00, '0, "R8 no allocate", 4, 0);

    // R7: bypass
    cache_off = 1'b1;
    xfer(1'b0, A(1, 1, 0), 8'h00, '0, "R7 bypass read", 1, 0);
    xfer(1'b1, A(20, 1, 0), 8'hFF, 64'hABCD_0000_1234_5678, "R7 bypass write", 0, 1);
    chk("R7 bypass write reached memory", 64'(mem_diff()), 0);
    cache_off = 1'b0;
    xfer(1'b0, A(1, 1, 0), 8'h00, '0, "R7 contents retained", 0, 0);

    // R9 R12: allocate on write miss, then flush
    wb_mode = 1'b1;
    for (int s = 0; s < 4; s++)
      xfer(1'b1, A(7, s, 0), 8'hFF, 64'(s) * 64'h0101_0101_0101_0101, "R9 wb write miss allocate", 4, 0);
    chk("R9 allocated lines not in memory", 64'(mem_diff() != 0), 1);
    w0 = wr_cnt;
    flush_req = 1'b1;
    @(posedge clk);
    #1 flush_req = 1'b0;
    chk("R12 busy during flush", 64'(busy), 1);
    @(negedge clk);
    while (busy) @(negedge clk);
    chk("R12 flush write beats", 64'(wr_cnt - w0), 16);
    chk("R12 memory matches after flush", 64'(mem_diff()), 0);
    @(posedge clk); #1;
    for (int s = 0; s < 4; s++) xfer(1'b0, A(7, s, 0), 8'h00, '0, "R12 invalid after flush", 4, 0);

    chk("R13 request held until ack", 64'(hs_err), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule